// File: doc/BRIEF.md
# Sub-Port Address Tag Extractor and Inserter

This block sits on the cell streams that cross a serial bridge and carries a 3-bit sub-port tag inside the cells. The tag lives in one byte of each cell, and that byte is chosen when the block is configured. It can be a user prepend byte, a header byte or one of the two user-defined bytes, and all of them are reached through a single byte index counted from the first byte of the cell. A bit offset places the 3-bit field within that byte.

The extract direction reads the field from every incoming cell. It joins the field with the 5-bit port address to form an 8-bit sub-port identifier, `{tag, port}`, and passes the cell through unchanged. The insert direction does the reverse on outgoing cells. It writes the upper 3 bits of a supplied 8-bit identifier into the chosen field and reports the lower 5 bits as the cell's port.

Both directions use valid/ready streams with start-of-cell and end-of-cell marks. Cells are up to 64 bytes long, on an 8-bit or a 16-bit data path.

Top module: `subport_tagger`

## Requirements
- R1: The extract identifier equals `{tag, port}`, with the port address in bits 4:0. The tag is bits `[off+2:off]` of the cell byte whose zero-based index is the configured byte index. On a 16-bit path, even-indexed bytes sit in bits 15:8 of a word and odd-indexed bytes sit in bits 7:0.
- R2: A configured bit offset of 6 or 7 acts as offset 5, so the field always fits inside the byte.
- R3: The identifier-valid output is low on the output words that come before the word holding the field. It is high on that word and on every later word of the same cell.
- R4: Insertion replaces the 3-bit field of the target byte with bits 7:5 of the supplied identifier. Every other bit of that byte, and every other byte of the cell, passes through unchanged. The insert port output shows bits 4:0 of the identifier taken at the start-of-cell word and holds that value through the cell.
- R5: If a cell ends before the configured byte, the error output is high on that cell's end-of-cell output word, the identifier-valid output stays low, and inserted data is unchanged. The error output is low on every other word.
- R6: The byte index and bit offset are taken from the start-of-cell word. Changes to them during the rest of the cell have no effect on that cell.
- R7: Each direction holds one register stage. An accepted word appears on the output in the next cycle with its start and end marks. While the output is valid and not taken, the output is held and the input is not ready. Input ready equals (not output-valid) or output-ready.
- R8: After reset, both output-valid signals are low and both input-ready signals are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgByteIdx | input | 6 | Index of the byte carrying the tag, counted from the start of the cell |
| cfgBitOff | input | 3 | Position of the lowest tag bit within that byte |
| exInValid | input | 1 | Extract input word valid |
| exInReady | output | 1 | Extract input can accept a word |
| exInData | input | 16 | Extract input word |
| exInSoc | input | 1 | Extract input word is the first of a cell |
| exInEoc | input | 1 | Extract input word is the last of a cell |
| exInPort | input | 5 | Port address of the incoming cell |
| exOutValid | output | 1 | Extract output word valid |
| exOutReady | input | 1 | Downstream takes the extract output word |
| exOutData | output | 16 | Extract output word, unchanged from the input |
| exOutSoc | output | 1 | First-word mark on the extract output |
| exOutEoc | output | 1 | Last-word mark on the extract output |
| exOutSubId | output | 8 | Sub-port identifier {tag, port} |
| exOutIdValid | output | 1 | Identifier valid for this cell |
| exOutErr | output | 1 | Cell ended before the tag byte |
| insInValid | input | 1 | Insert input word valid |
| insInReady | output | 1 | Insert input can accept a word |
| insInData | input | 16 | Insert input word |
| insInSoc | input | 1 | Insert input word is the first of a cell |
| insInEoc | input | 1 | Insert input word is the last of a cell |
| insInSubId | input | 8 | Identifier to insert: tag in bits 7:5, port in 4:0 |
| insOutValid | output | 1 | Insert output word valid |
| insOutReady | input | 1 | Downstream takes the insert output word |
| insOutData | output | 16 | Insert output word with the tag written in |
| insOutSoc | output | 1 | First-word mark on the insert output |
| insOutEoc | output | 1 | Last-word mark on the insert output |
| insOutPort | output | 5 | Port address of the outgoing cell |
| insOutErr | output | 1 | Cell ended before the tag byte |

## Verification
Every result of this block is due exactly one clock after its word is accepted. This covers the passed-through word and its marks, the identifier and its valid flag, the error flag and the patched word. The bench drives a word, waits for the accepting edge and compares a time unit later, against values computed from the byte pattern and the byte and bit settings. Input ready is the one combinational result, so under stall it is compared a time unit after the downstream ready changes, before the next edge.

// File: rtl/subtag_pkg.sv
package subtag_pkg;
  localparam int TAG_W   = 3;
  localparam int OFF_W   = 3;
  localparam int MAX_OFF = 8 - TAG_W;

  // Per-word strobes from a stream controller to the datapath.
  typedef struct packed {
    logic             take;    // word accepted this cycle
    logic             first;   // accepted word opens a cell
    logic             hit;     // word holds the tag byte
    logic             early;   // cell closes without the tag byte
    logic             hiByte;  // tag byte sits in the upper half of the word
    logic [OFF_W-1:0] off;     // clamped bit offset of the field
  } strb_t;
endpackage

// File: rtl/subtag_ctrl.sv
module subtag_ctrl
  import subtag_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int MAX_CELL_BYTES = 64,
  localparam int IDX_W         = $clog2(MAX_CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inReady,
  input  logic             inSoc,
  input  logic             inEoc,
  input  logic [IDX_W-1:0] cfgByteIdx,
  input  logic [OFF_W-1:0] cfgBitOff,
  output strb_t            strb
);
  localparam int BPW        = DATA_W / 8;
  localparam int WORD_SHIFT = $clog2(BPW);
  localparam int MAX_WORDS  = MAX_CELL_BYTES / BPW;
  localparam int WCNT_W     = $clog2(MAX_WORDS) + 1;
  localparam logic [WCNT_W-1:0] CNT_TOP = '1;
  localparam logic [OFF_W-1:0]  OFF_LIM = OFF_W'(MAX_OFF);

  logic              take;
  logic              seenQ;
  logic              seenEff;
  logic              hitNow;
  logic [WCNT_W-1:0] wordCnt;
  logic [WCNT_W-1:0] curWord;
  logic [WCNT_W-1:0] tgtWord;
  logic [IDX_W-1:0]  idxQ;
  logic [IDX_W-1:0]  idxEff;
  logic [OFF_W-1:0]  offQ;
  logic [OFF_W-1:0]  offEff;

  // The start-of-cell word uses the live settings; later words use the copy.
  always_comb begin
    take    = inValid && inReady;
    idxEff  = inSoc ? cfgByteIdx : idxQ;
    offEff  = inSoc ? cfgBitOff : offQ;
    curWord = inSoc ? '0 : wordCnt;
    tgtWord = WCNT_W'(idxEff >> WORD_SHIFT);
    seenEff = inSoc ? 1'b0 : seenQ;
    hitNow  = (curWord == tgtWord) && !seenEff;

    strb.take   = take;
    strb.first  = inSoc;
    strb.hit    = hitNow;
    strb.early  = inEoc && !hitNow && !seenEff;
    strb.hiByte = (BPW > 1) ? ~idxEff[0] : 1'b0;
    strb.off    = (offEff > OFF_LIM) ? OFF_LIM : offEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordCnt <= '0;
      seenQ   <= 1'b0;
      idxQ    <= '0;
      offQ    <= '0;
    end else if (take) begin
      wordCnt <= (curWord == CNT_TOP) ? CNT_TOP : curWord + 1'b1;
      seenQ   <= seenEff || hitNow;
      if (inSoc) begin
        idxQ <= cfgByteIdx;
        offQ <= cfgBitOff;
      end
    end
  end
endmodule

// File: rtl/subtag_dp.sv
module subtag_dp
  import subtag_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PORT_W  = 5,
  localparam int ID_W   = PORT_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             exStrb,
  input  strb_t             insStrb,
  input  logic              exInValid,
  output logic              exInReady,
  input  logic [DATA_W-1:0] exInData,
  input  logic              exInSoc,
  input  logic              exInEoc,
  input  logic [PORT_W-1:0] exInPort,
  output logic              exOutValid,
  input  logic              exOutReady,
  output logic [DATA_W-1:0] exOutData,
  output logic              exOutSoc,
  output logic              exOutEoc,
  output logic [ID_W-1:0]   exOutSubId,
  output logic              exOutIdValid,
  output logic              exOutErr,
  input  logic              insInValid,
  output logic              insInReady,
  input  logic [DATA_W-1:0] insInData,
  input  logic              insInSoc,
  input  logic              insInEoc,
  input  logic [ID_W-1:0]   insInSubId,
  output logic              insOutValid,
  input  logic              insOutReady,
  output logic [DATA_W-1:0] insOutData,
  output logic              insOutSoc,
  output logic              insOutEoc,
  output logic [PORT_W-1:0] insOutPort,
  output logic              insOutErr
);
  localparam logic [7:0] TAG_ONES = 8'((1 << TAG_W) - 1);

  function automatic logic [7:0] pickByte(input logic [DATA_W-1:0] word, input logic hi);
    return hi ? word[DATA_W-1 -: 8] : word[7:0];
  endfunction

  logic [7:0]        exByte;
  logic [TAG_W-1:0]  exTag;
  logic [7:0]        insByte;
  logic [7:0]        fieldMask;
  logic [7:0]        newByte;
  logic [DATA_W-1:0] patched;

  assign exInReady  = !exOutValid || exOutReady;
  assign insInReady = !insOutValid || insOutReady;

  always_comb begin
    exByte    = pickByte(exInData, exStrb.hiByte);
    exTag     = TAG_W'(exByte >> exStrb.off);
    insByte   = pickByte(insInData, insStrb.hiByte);
    fieldMask = TAG_ONES << insStrb.off;
    newByte   = (insByte & ~fieldMask) | (8'(insInSubId[ID_W-1 -: TAG_W]) << insStrb.off);
    patched   = insInData;
    if (insStrb.hit) begin
      if (insStrb.hiByte) patched[DATA_W-1 -: 8] = newByte;
      else                patched[7:0]           = newByte;
    end
  end

  // Extract direction: word passes through, identifier follows the cell.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exOutValid   <= 1'b0;
      exOutData    <= '0;
      exOutSoc     <= 1'b0;
      exOutEoc     <= 1'b0;
      exOutSubId   <= '0;
      exOutIdValid <= 1'b0;
      exOutErr     <= 1'b0;
    end else begin
      if (exInReady) exOutValid <= exInValid;
      if (exStrb.take) begin
        exOutData <= exInData;
        exOutSoc  <= exInSoc;
        exOutEoc  <= exInEoc;
        exOutErr  <= exStrb.early;
        if (exStrb.hit) begin
          exOutSubId   <= {exTag, exInPort};
          exOutIdValid <= 1'b1;
        end else if (exStrb.first) begin
          exOutSubId   <= '0;
          exOutIdValid <= 1'b0;
        end
      end
    end
  end

  // Insert direction: field written into the chosen byte.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insOutValid <= 1'b0;
      insOutData  <= '0;
      insOutSoc   <= 1'b0;
      insOutEoc   <= 1'b0;
      insOutPort  <= '0;
      insOutErr   <= 1'b0;
    end else begin
      if (insInReady) insOutValid <= insInValid;
      if (insStrb.take) begin
        insOutData <= patched;
        insOutSoc  <= insInSoc;
        insOutEoc  <= insInEoc;
        insOutErr  <= insStrb.early;
        if (insStrb.first) insOutPort <= insInSubId[PORT_W-1:0];
      end
    end
  end

  AST_EX_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    exOutValid && !exOutReady |=> exOutValid && $stable(exOutData) && $stable(exOutSubId)); // R7
  AST_INS_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    insOutValid && !insOutReady |=> insOutValid && $stable(insOutData)); // R7
  AST_ID_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    exStrb.take && !exStrb.first && exOutIdValid |=> exOutIdValid && $stable(exOutSubId)); // R3
  AST_EX_ERR_AT_EOC: assert property (@(posedge clk) disable iff (!rstN)
    exOutValid && exOutErr |-> exOutEoc && !exOutIdValid); // R5
  AST_INS_ERR_AT_EOC: assert property (@(posedge clk) disable iff (!rstN)
    insOutValid && insOutErr |-> insOutEoc); // R5
  AST_INS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    insStrb.take && !insStrb.hit |=> insOutData == $past(insInData)); // R4
  AST_INS_PORT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    insStrb.take && !insStrb.first |=> $stable(insOutPort)); // R4
endmodule

// File: rtl/subport_tagger.sv
module subport_tagger
  import subtag_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int MAX_CELL_BYTES = 64,
  parameter int PORT_W         = 5,
  localparam int IDX_W         = $clog2(MAX_CELL_BYTES),
  localparam int ID_W          = PORT_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cfgByteIdx,
  input  logic [OFF_W-1:0]  cfgBitOff,
  input  logic              exInValid,
  output logic              exInReady,
  input  logic [DATA_W-1:0] exInData,
  input  logic              exInSoc,
  input  logic              exInEoc,
  input  logic [PORT_W-1:0] exInPort,
  output logic              exOutValid,
  input  logic              exOutReady,
  output logic [DATA_W-1:0] exOutData,
  output logic              exOutSoc,
  output logic              exOutEoc,
  output logic [ID_W-1:0]   exOutSubId,
  output logic              exOutIdValid,
  output logic              exOutErr,
  input  logic              insInValid,
  output logic              insInReady,
  input  logic [DATA_W-1:0] insInData,
  input  logic              insInSoc,
  input  logic              insInEoc,
  input  logic [ID_W-1:0]   insInSubId,
  output logic              insOutValid,
  input  logic              insOutReady,
  output logic [DATA_W-1:0] insOutData,
  output logic              insOutSoc,
  output logic              insOutEoc,
  output logic [PORT_W-1:0] insOutPort,
  output logic              insOutErr
);
  strb_t exStrb;
  strb_t insStrb;

  subtag_ctrl #(.DATA_W(DATA_W), .MAX_CELL_BYTES(MAX_CELL_BYTES)) u_exCtrl (
    .clk(clk), .rstN(rstN), .inValid(exInValid), .inReady(exInReady),
    .inSoc(exInSoc), .inEoc(exInEoc), .cfgByteIdx(cfgByteIdx),
    .cfgBitOff(cfgBitOff), .strb(exStrb)
  );

  subtag_ctrl #(.DATA_W(DATA_W), .MAX_CELL_BYTES(MAX_CELL_BYTES)) u_insCtrl (
    .clk(clk), .rstN(rstN), .inValid(insInValid), .inReady(insInReady),
    .inSoc(insInSoc), .inEoc(insInEoc), .cfgByteIdx(cfgByteIdx),
    .cfgBitOff(cfgBitOff), .strb(insStrb)
  );

  subtag_dp #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .exStrb(exStrb), .insStrb(insStrb),
    .exInValid(exInValid), .exInReady(exInReady), .exInData(exInData),
    .exInSoc(exInSoc), .exInEoc(exInEoc), .exInPort(exInPort),
    .exOutValid(exOutValid), .exOutReady(exOutReady), .exOutData(exOutData),
    .exOutSoc(exOutSoc), .exOutEoc(exOutEoc), .exOutSubId(exOutSubId),
    .exOutIdValid(exOutIdValid), .exOutErr(exOutErr),
    .insInValid(insInValid), .insInReady(insInReady), .insInData(insInData),
    .insInSoc(insInSoc), .insInEoc(insInEoc), .insInSubId(insInSubId),
    .insOutValid(insOutValid), .insOutReady(insOutReady), .insOutData(insOutData),
    .insOutSoc(insOutSoc), .insOutEoc(insOutEoc), .insOutPort(insOutPort),
    .insOutErr(insOutErr)
  );
endmodule

// File: tb/subport_tagger_tb.sv
module subport_tagger_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [5:0]  cfgByteIdx;
  logic [2:0]  cfgBitOff;
  logic        exInValid, exInReady, exInSoc, exInEoc;
  logic [15:0] exInData;
  logic [4:0]  exInPort;
  logic        exOutValid, exOutReady, exOutSoc, exOutEoc, exOutIdValid, exOutErr;
  logic [15:0] exOutData;
  logic [7:0]  exOutSubId;
  logic        insInValid, insInReady, insInSoc, insInEoc;
  logic [15:0] insInData;
  logic [7:0]  insInSubId;
  logic        insOutValid, insOutReady, insOutSoc, insOutEoc, insOutErr;
  logic [15:0] insOutData;
  logic [4:0]  insOutPort;

  int total = 0;
  int bad   = 0;
  int cid   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subport_tagger u_dut (
    .clk(clk), .rstN(rstN), .cfgByteIdx(cfgByteIdx), .cfgBitOff(cfgBitOff),
    .exInValid(exInValid), .exInReady(exInReady), .exInData(exInData),
    .exInSoc(exInSoc), .exInEoc(exInEoc), .exInPort(exInPort),
    .exOutValid(exOutValid), .exOutReady(exOutReady), .exOutData(exOutData),
    .exOutSoc(exOutSoc), .exOutEoc(exOutEoc), .exOutSubId(exOutSubId),
    .exOutIdValid(exOutIdValid), .exOutErr(exOutErr),
    .insInValid(insInValid), .insInReady(insInReady), .insInData(insInData),
    .insInSoc(insInSoc), .insInEoc(insInEoc), .insInSubId(insInSubId),
    .insOutValid(insOutValid), .insOutReady(insOutReady), .insOutData(insOutData),
    .insOutSoc(insOutSoc), .insOutEoc(insOutEoc), .insOutPort(insOutPort),
    .insOutErr(insOutErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(input int c, input int b);
    return 8'((c * 37 + b * 11 + 5) & 255);
  endfunction

  function automatic logic [15:0] wordOf(input int c, input int w);
    return {byteOf(c, 2 * w), byteOf(c, 2 * w + 1)};
  endfunction

  // One cell on both streams; settings after the first word may differ (R6).
  task automatic runCell(input int nw, input int idx, input int off, input int port,
                         input int tag, input int newIdx, input int newOff, input bit mid);
    int tw = idx / 2;
    int o  = (off > 5) ? 5 : off;
    logic [2:0] etag = 3'((byteOf(cid, idx) >> o) & 7);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] insExp;
      logic [7:0]  nb;
      logic        expV;
      logic        expErr;
      cfgByteIdx = 6'((w == 0) ? idx : newIdx);
      cfgBitOff  = 3'((w == 0) ? off : newOff);
      exInValid  = 1'b1;
      exInData   = wordOf(cid, w);
      exInSoc    = (w == 0);
      exInEoc    = (w == nw - 1);
      exInPort   = 5'(port);
      insInValid = 1'b1;
      insInData  = wordOf(cid, w);
      insInSoc   = (w == 0);
      insInEoc   = (w == nw - 1);
      insInSubId = {3'(tag), 5'(port)};
      @(posedge clk);
      #1;
      chk("R7", {exOutValid, exOutSoc, exOutEoc, exOutData},
          {1'b1, (w == 0), (w == nw - 1), wordOf(cid, w)});
      chk("R7", {insOutValid, insOutSoc, insOutEoc}, {1'b1, (w == 0), (w == nw - 1)});
      expV = (tw < nw) && (w >= tw);
      chk("R3", exOutIdValid, expV);
      if (expV) chk(mid ? "R6" : ((off > 5) ? "R2" : "R1"), exOutSubId, {etag, 5'(port)});
      expErr = (w == nw - 1) && (tw >= nw);
      chk("R5", exOutErr, expErr);
      chk("R5", insOutErr, expErr);
      insExp = wordOf(cid, w);
      if (w == tw) begin
        nb = (byteOf(cid, idx) & ~(8'h07 << o)) | (8'(tag) << o);
        if (idx % 2 == 0) insExp[15:8] = nb;
        else              insExp[7:0]  = nb;
      end
      chk(mid ? "R6" : "R4", insOutData, insExp);
      chk("R4", insOutPort, port);
    end
    cid++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    cfgByteIdx = '0; cfgBitOff = '0;
    exInValid = 0; exInData = '0; exInSoc = 0; exInEoc = 0; exInPort = '0; exOutReady = 1;
    insInValid = 0; insInData = '0; insInSoc = 0; insInEoc = 0; insInSubId = '0; insOutReady = 1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", {exOutValid, insOutValid, exInReady, insInReady}, 4'b0011);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R8", {exOutValid, insOutValid}, 2'b00);

    // Sweep every byte of a 16-byte cell and every bit offset (R1 R2 R3 R4).
    for (int idx = 0; idx < 16; idx++)
      for (int off = 0; off < 8; off++)
        runCell(8, idx, off, (idx * 3 + off) % 32, (idx + off) % 8, idx, off, 1'b0);

    // Cells that end before or exactly at the tag byte (R5).
    runCell(3, 10, 2, 7, 5, 10, 2, 1'b0);
    runCell(1, 1, 4, 9, 3, 1, 4, 1'b0);
    runCell(1, 2, 4, 9, 3, 2, 4, 1'b0);
    runCell(32, 63, 2, 17, 6, 63, 2, 1'b0);
    runCell(6, 12, 0, 21, 2, 12, 0, 1'b0);

    // Settings changed after the first word must not matter (R6).
    runCell(8, 2, 1, 11, 4, 13, 4, 1'b1);
    runCell(8, 13, 4, 11, 4, 13, 4, 1'b0);
    runCell(8, 5, 7, 30, 1, 0, 0, 1'b1);

    // Back-pressure on the extract output (R7).
    exInValid = 0; insInValid = 0;
    @(posedge clk);
    #1;
    cfgByteIdx = 6'd0; cfgBitOff = 3'd0;
    exInValid = 1; exInData = 16'hA1B2; exInSoc = 1; exInEoc = 0; exInPort = 5'd3;
    @(posedge clk);
    #1;
    chk("R7", {exOutValid, exOutData}, {1'b1, 16'hA1B2});
    exOutReady = 0;
    exInData = 16'hC3D4; exInSoc = 0; exInEoc = 1;
    #1;
    chk("R7", exInReady, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      chk("R7", {exOutValid, exOutData, exInReady}, {1'b1, 16'hA1B2, 1'b0});
      chk("R3", {exOutIdValid, exOutSubId}, {1'b1, 3'((8'hA1 >> 0) & 7), 5'd3});
    end
    exOutReady = 1;
    #1;
    chk("R7", exInReady, 1'b1);
    @(posedge clk);
    #1;
    chk("R7", {exOutValid, exOutEoc, exOutData}, {1'b1, 1'b1, 16'hC3D4});
    exInValid = 0;
    @(posedge clk);
    #1;
    chk("R7", exOutValid, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule